// File: doc/BRIEF.md
# Banked Register AND Execution Unit

This unit carries out one single-word instruction: the bitwise AND of the working register with one byte of data memory. A 16-bit instruction word is presented at the start of an instruction cycle. The unit decodes it and forms a 12-bit data address in one of three ways: a bank-register base, a split access bank, or a pointer plus an 8-bit offset. It reads the operand through a synchronous register-file port and computes the AND. The result is then written either to the working register or back to the memory byte, and the negative and zero flags are updated.

Each instruction cycle has four internal phases, held in a free-running counter that is visible at the ports: decode, operand read, compute, write-back. The rest of the core can load the working register and the status flags at any clock. When such a load coincides with the write-back phase, a fixed priority settles which value each field takes. Instruction words with any other opcode are ignored.

Top module: `bank_and_unit`

## Requirements
- R1: An instruction executes only when `instr_valid` is high in the decode phase and `instr_word[15:10]` equals `000101`. Any other word causes no register-file read, no register-file write and no change to `w_out` or `flags_out`, apart from an external load.
- R2: The result is `w_out & operand`, where the operand is the byte at the effective address.
- R3: When `instr_word[9]` is 0, the result goes to the working register and the register file is not written. When it is 1, the result is written to the effective address and the working register keeps its value.
- R4: When `instr_word[8]` is 1, the effective address is `{bank_reg, instr_word[7:0]}`.
- R5: When `instr_word[8]` is 0 and indexed mode does not apply, offsets 0x00–0x5F address 0x000–0x05F and offsets 0x60–0xFF address 0xF60–0xFFF.
- R6: When `instr_word[8]` is 0, `idx_mode_en` is 1 and the offset is 0x5F or less, the effective address is `(idx_ptr + offset) mod 4096`.
- R7: `flags_out` is {N, Z, OV, DC, C} from bit 4 down to bit 0. An executed instruction sets Z when the result is zero and copies result bit 7 into N. OV, DC and C change only through an external load.
- R8: After reset, `phase_out` counts 0,1,2,3 repeatedly. The read request with its address appears in phase 1. The write request appears in phase 3. The working register and the flags take their new values at the clock edge that ends phase 3.
- R9: While `rst` is high, `phase_out`, `w_out` and `flags_out` are zero and both register-file enables are low.
- R10: When `ctx_load` is high, `w_out` takes `ctx_w` and `flags_out` takes `ctx_flags` at the next edge. In the write-back phase of an executing instruction, the fields that the instruction writes (N, Z, and W when the destination is W) take the result, and the remaining fields take the load.
- R11: The compute step uses the working register as it stands at the end of phase 2. A load that lands at the end of phase 0 or phase 1 therefore feeds the AND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present (sampled in phase 0) |
| instr_word | input | 16 | Instruction word |
| bank_reg | input | 4 | Bank base for banked addressing |
| idx_mode_en | input | 1 | Enables pointer-indexed addressing |
| idx_ptr | input | 12 | Pointer base for indexed addressing |
| ctx_load | input | 1 | Load working register and flags |
| ctx_w | input | 8 | Working-register load value |
| ctx_flags | input | 5 | Flag load value {N,Z,OV,DC,C} |
| rf_addr | output | 12 | Register-file address |
| rf_rd_en | output | 1 | Register-file read request |
| rf_rdata | input | 8 | Read data, valid the cycle after the request |
| rf_wr_en | output | 1 | Register-file write request |
| rf_wdata | output | 8 | Register-file write data |
| w_out | output | 8 | Working register |
| flags_out | output | 5 | Status flags {N,Z,OV,DC,C} |
| phase_out | output | 2 | Current phase 0..3 |

## Verification
Two things can touch the working register and the flags at the same clock edge: the write-back at the end of phase 3 and an external context load. The bench provokes this with directed and randomly placed loads in each of the four phases, with both destination settings. It judges every outcome field by field against a model that applies the R10 priority. Loads placed in phases 0 to 2 also check which W value the AND consumed.

// File: rtl/bank_and_pkg.sv
package bank_and_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned OFS_W   = 8;
    localparam int unsigned BANK_W  = 4;
    localparam int unsigned ADDR_W  = BANK_W + OFS_W;
    localparam int unsigned INSTR_W = 16;
    localparam int unsigned OPC_W   = 6;
    localparam logic [OPC_W-1:0] OPC_AND = 6'b000101;
    localparam logic [OFS_W-1:0] ACC_SPLIT = 8'h60;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_CALC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        AM_ACCESS  = 2'd0,
        AM_BANKED  = 2'd1,
        AM_INDEXED = 2'd2
    } amode_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic dcarry;
        logic carry;
    } flags_t;

    typedef struct packed {
        logic              to_mem;
        logic [ADDR_W-1:0] ea;
    } op_t;

    function automatic logic is_andop(input logic [INSTR_W-1:0] word);
        return word[INSTR_W-1 -: OPC_W] == OPC_AND;
    endfunction

    function automatic logic [1:0] nz_of(input logic [DATA_W-1:0] r);
        return {r[DATA_W-1], (r == '0)};
    endfunction

endpackage

// File: rtl/bank_and_phase.sv
module bank_and_phase
    import bank_and_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);
    logic [1:0] nxt;

    assign nxt = phase + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_DECODE;
        else     phase <= phase_e'(nxt);
    end

    // R8: phases advance one step per clock and wrap
    p_phase_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WRITE |=> phase == PH_DECODE);
    p_phase_step_r8: assert property (@(posedge clk) disable iff (rst)
        phase != PH_WRITE |=> phase != PH_DECODE && phase != $past(phase));

endmodule

// File: rtl/bank_and_addr.sv
module bank_and_addr
    import bank_and_pkg::*;
#(
    parameter int unsigned P_OFS_W  = OFS_W,
    parameter int unsigned P_BANK_W = BANK_W,
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter logic [P_OFS_W-1:0] P_SPLIT = ACC_SPLIT
) (
    input  logic [P_OFS_W-1:0]  ofs,
    input  logic                use_bank,
    input  logic [P_BANK_W-1:0] bank,
    input  logic                idx_en,
    input  logic [P_ADDR_W-1:0] ptr,
    output logic [P_ADDR_W-1:0] ea
);
    localparam int unsigned HI_W = P_ADDR_W - P_OFS_W;

    amode_e              mode;
    logic                low_half;
    logic [P_ADDR_W-1:0] ofs_ext;
    logic [P_ADDR_W-1:0] acc_addr;
    logic [P_ADDR_W-1:0] bank_addr;

    assign low_half = ofs < P_SPLIT;
    assign ofs_ext  = {{HI_W{1'b0}}, ofs};

    generate
        if (HI_W == P_BANK_W) begin : g_bank_exact
            assign bank_addr = {bank, ofs};
        end else begin : g_bank_pad
            assign bank_addr = P_ADDR_W'({bank, ofs});
        end
    endgenerate

    assign acc_addr = low_half ? ofs_ext : {{HI_W{1'b1}}, ofs};

    always_comb begin
        if (use_bank)               mode = AM_BANKED;
        else if (idx_en && low_half) mode = AM_INDEXED;
        else                        mode = AM_ACCESS;
    end

    always_comb begin
        unique case (mode)
            AM_BANKED:  ea = bank_addr;
            AM_INDEXED: ea = ptr + ofs_ext;
            default:    ea = acc_addr;
        endcase
    end

endmodule

// File: rtl/bank_and_ctx.sv
module bank_and_ctx
    import bank_and_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_w,
    input  flags_t            ld_fl,
    input  logic              wb_w_en,
    input  logic [DATA_W-1:0] wb_w,
    input  logic              wb_nz_en,
    input  logic [1:0]        wb_nz,
    output logic [DATA_W-1:0] w_q,
    output flags_t            fl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            w_q  <= '0;
            fl_q <= '0;
        end else begin
            if (wb_w_en)    w_q <= wb_w;
            else if (ld_en) w_q <= ld_w;

            if (ld_en) begin
                fl_q.ovf    <= ld_fl.ovf;
                fl_q.dcarry <= ld_fl.dcarry;
                fl_q.carry  <= ld_fl.carry;
            end

            if (wb_nz_en) begin
                fl_q.neg  <= wb_nz[1];
                fl_q.zero <= wb_nz[0];
            end else if (ld_en) begin
                fl_q.neg  <= ld_fl.neg;
                fl_q.zero <= ld_fl.zero;
            end
        end
    end

    // R7: arithmetic flags only move on a load
    p_keep_flags_r7: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(fl_q.ovf) && $stable(fl_q.dcarry) && $stable(fl_q.carry));
    // R3: working register holds unless written or loaded
    p_w_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !ld_en && !wb_w_en |=> $stable(w_q));
    // R10: write-back wins over a load for N and Z
    p_wb_priority_r10: assert property (@(posedge clk) disable iff (rst)
        wb_nz_en |=> fl_q.neg == $past(wb_nz[1]) && fl_q.zero == $past(wb_nz[0]));

endmodule

// File: rtl/bank_and_unit.sv
module bank_and_unit
    import bank_and_pkg::*;
#(
    parameter int unsigned P_DATA_W  = DATA_W,
    parameter int unsigned P_ADDR_W  = ADDR_W,
    parameter int unsigned P_BANK_W  = BANK_W,
    parameter int unsigned P_INSTR_W = INSTR_W,
    parameter int unsigned P_FLAG_W  = $bits(flags_t)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid,
    input  logic [P_INSTR_W-1:0] instr_word,
    input  logic [P_BANK_W-1:0]  bank_reg,
    input  logic                 idx_mode_en,
    input  logic [P_ADDR_W-1:0]  idx_ptr,
    input  logic                 ctx_load,
    input  logic [P_DATA_W-1:0]  ctx_w,
    input  logic [P_FLAG_W-1:0]  ctx_flags,
    output logic [P_ADDR_W-1:0]  rf_addr,
    output logic                 rf_rd_en,
    input  logic [P_DATA_W-1:0]  rf_rdata,
    output logic                 rf_wr_en,
    output logic [P_DATA_W-1:0]  rf_wdata,
    output logic [P_DATA_W-1:0]  w_out,
    output logic [P_FLAG_W-1:0]  flags_out,
    output logic [1:0]           phase_out
);
    localparam int unsigned BIT_DEST = OFS_W + 1;
    localparam int unsigned BIT_BANK = OFS_W;

    phase_e              phase;
    logic                dec_hit;
    logic [P_ADDR_W-1:0] dec_ea;
    logic                active;
    op_t                 op_q;
    logic [P_DATA_W-1:0] res_q;
    logic [P_DATA_W-1:0] w_q;
    flags_t              fl_q;
    logic                in_wb;

    bank_and_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    assign dec_hit = instr_valid && is_andop(instr_word);

    bank_and_addr u_addr (
        .ofs      (instr_word[OFS_W-1:0]),
        .use_bank (instr_word[BIT_BANK]),
        .bank     (bank_reg),
        .idx_en   (idx_mode_en),
        .ptr      (idx_ptr),
        .ea       (dec_ea)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            op_q   <= '0;
            res_q  <= '0;
        end else begin
            unique case (phase)
                PH_DECODE: begin
                    active <= dec_hit;
                    if (dec_hit) begin
                        op_q.to_mem <= instr_word[BIT_DEST];
                        op_q.ea     <= dec_ea;
                    end
                end
                PH_CALC: begin
                    if (active) res_q <= w_q & rf_rdata;
                end
                PH_WRITE: active <= 1'b0;
                default: ;
            endcase
        end
    end

    assign in_wb = active && (phase == PH_WRITE);

    bank_and_ctx u_ctx (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ctx_load),
        .ld_w     (ctx_w),
        .ld_fl    (flags_t'(ctx_flags)),
        .wb_w_en  (in_wb && !op_q.to_mem),
        .wb_w     (res_q),
        .wb_nz_en (in_wb),
        .wb_nz    (nz_of(res_q)),
        .w_q      (w_q),
        .fl_q     (fl_q)
    );

    assign rf_rd_en  = active && (phase == PH_READ);
    assign rf_wr_en  = in_wb && op_q.to_mem;
    assign rf_addr   = active ? op_q.ea : '0;
    assign rf_wdata  = res_q;
    assign w_out     = w_q;
    assign flags_out = fl_q;
    assign phase_out = phase;

    // R8: port requests only in their own phase
    p_read_phase_r8: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |-> phase_out == 2'd1);
    p_write_phase_r8: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> phase_out == 2'd3);
    // R1: a foreign opcode leads to no read in the following phase
    p_ignore_foreign_r1: assert property (@(posedge clk) disable iff (rst)
        phase_out == 2'd0 && !(instr_valid && instr_word[15:10] == 6'b000101) |=> !rf_rd_en);
    // R3: memory destination leaves W alone unless loaded
    p_mem_dest_r3: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en && !ctx_load |=> $stable(w_out));
    // R7: Z and N follow the byte written back
    p_nz_from_result_r7: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |=> flags_out[3] == ($past(rf_wdata) == 8'h00) && flags_out[4] == $past(rf_wdata[7]));

endmodule

// File: tb/tb_bank_and_unit.sv
`timescale 1ns/1ps
module tb_bank_and_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic [3:0]  bank_reg;
    logic        idx_mode_en;
    logic [11:0] idx_ptr;
    logic        ctx_load;
    logic [7:0]  ctx_w;
    logic [4:0]  ctx_flags;
    logic [11:0] rf_addr;
    logic        rf_rd_en;
    logic [7:0]  rf_rdata;
    logic        rf_wr_en;
    logic [7:0]  rf_wdata;
    logic [7:0]  w_out;
    logic [4:0]  flags_out;
    logic [1:0]  phase_out;

    logic [7:0]  ram [4096];
    logic [7:0]  w_m;
    logic [4:0]  f_m;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;

    always #4 clk = ~clk;

    bank_and_unit dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .bank_reg(bank_reg), .idx_mode_en(idx_mode_en), .idx_ptr(idx_ptr),
        .ctx_load(ctx_load), .ctx_w(ctx_w), .ctx_flags(ctx_flags),
        .rf_addr(rf_addr), .rf_rd_en(rf_rd_en), .rf_rdata(rf_rdata),
        .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata), .w_out(w_out),
        .flags_out(flags_out), .phase_out(phase_out)
    );

    always @(posedge clk) begin
        if (rf_rd_en) rf_rdata <= ram[rf_addr];
        if (rf_wr_en) ram[rf_addr] <= rf_wdata;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] m_ea(input logic [7:0] f, input logic a,
        input logic [3:0] b, input logic x, input logic [11:0] p);
        if (a)                  return {b, f};
        if (x && f <= 8'h5F)    return p + {4'h0, f};
        if (f <= 8'h5F)         return {4'h0, f};
        return {4'hF, f};
    endfunction

    function automatic string ea_tag(input logic [7:0] f, input logic a, input logic x);
        if (a)               return "R4 banked address";
        if (x && f <= 8'h5F) return "R6 indexed address";
        return "R5 access address";
    endfunction

    // Starts at a negedge in phase 0; ends at the next phase-0 negedge.
    task automatic exec(input logic [15:0] word, input logic [3:0] b, input logic x,
        input logic [11:0] p, input int lp, input logic [7:0] lw, input logic [4:0] lf);
        logic        hit;
        logic [11:0] ea;
        logic [7:0]  opnd, w_c, res;
        logic [4:0]  f_exp;
        logic [7:0]  w_exp;
        hit  = (word[15:10] == 6'b000101);
        ea   = m_ea(word[7:0], word[8], b, x, p);
        opnd = ram[ea];
        w_c  = (lp == 0 || lp == 1) ? lw : w_m;
        res  = w_c & opnd;
        instr_valid = 1'b1;
        instr_word  = word;
        bank_reg    = b;
        idx_mode_en = x;
        idx_ptr     = p;
        for (int ph = 0; ph < 4; ph++) begin
            chk(phase_out == 2'(ph), "R8 phase count", phase_out, ph);
            ctx_load  = (lp == ph);
            ctx_w     = lw;
            ctx_flags = lf;
            if (ph == 1) begin
                if (hit) chk(rf_rd_en && rf_addr == ea, ea_tag(word[7:0], word[8], x), rf_addr, ea);
                else     chk(!rf_rd_en, "R1 no read for foreign opcode", rf_rd_en, 0);
            end
            if (ph == 3) begin
                if (hit && word[9])
                    chk(rf_wr_en && rf_addr == ea && rf_wdata == res, "R3 memory write-back",
                        {rf_wr_en, rf_addr, rf_wdata}, {1'b1, ea, res});
                else
                    chk(!rf_wr_en, "R3 no memory write", rf_wr_en, 0);
            end
            @(negedge clk);
            instr_valid = 1'b0;
        end
        ctx_load = 1'b0;
        f_exp = (lp >= 0) ? lf : f_m;
        w_exp = (lp >= 0) ? lw : w_m;
        if (hit) begin
            f_exp[4] = res[7];
            f_exp[3] = (res == 8'h00);
            if (!word[9]) w_exp = res;
        end
        if (lp == 3)
            chk(w_out == w_exp && flags_out == f_exp, "R10 load meets write-back",
                {w_out, flags_out}, {w_exp, f_exp});
        else if (lp == 0 || lp == 1)
            chk(w_out == w_exp, "R11 early load feeds AND", w_out, w_exp);
        else if (hit)
            chk(w_out == w_exp, "R2 result in W", w_out, w_exp);
        else
            chk(w_out == w_exp, "R1 W unchanged", w_out, w_exp);
        chk(flags_out == f_exp, "R7 flags", flags_out, f_exp);
        w_m = w_exp;
        f_m = f_exp;
    endtask

    function automatic logic [15:0] andop(input logic d, input logic a, input logic [7:0] f);
        return {6'b000101, d, a, f};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) ram[i] = 8'((i * 37 + 5) & 255);
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0; bank_reg = '0;
        idx_mode_en = 1'b0; idx_ptr = '0; ctx_load = 1'b0; ctx_w = '0; ctx_flags = '0;
        w_m = '0; f_m = '0;
        repeat (3) @(negedge clk);
        chk(phase_out == 0 && w_out == 0 && flags_out == 0 && !rf_rd_en && !rf_wr_en,
            "R9 reset state", {phase_out, w_out, flags_out, rf_rd_en, rf_wr_en}, 0);
        rst = 1'b0;

        // R1 load via a foreign word, then the worked example
        exec(16'hFFFF, 4'h0, 1'b0, 12'h000, 0, 8'h17, 5'b00111);
        ram[12'h020] = 8'hC2;
        exec(andop(1'b0, 1'b0, 8'h20), 4'h0, 1'b0, 12'h000, -1, 8'h00, 5'h00);
        chk(w_out == 8'h02, "R2 example result", w_out, 8'h02);
        chk(ram[12'h020] == 8'hC2, "R3 memory kept with W destination", ram[12'h020], 8'hC2);
        // zero result written to memory
        exec(16'h0000, 4'h0, 1'b0, 12'h000, 0, 8'h0F, 5'b10000);
        ram[12'h0A33] = 8'hF0;
        exec(andop(1'b1, 1'b1, 8'h33), 4'hA, 1'b0, 12'h000, -1, 8'h00, 5'h00);
        chk(ram[12'hA33] == 8'h00, "R3 memory holds zero result", ram[12'hA33], 0);
        // address corners
        exec(andop(1'b0, 1'b0, 8'h20), 4'h3, 1'b1, 12'hFF0, -1, 8'h00, 5'h00);
        exec(andop(1'b0, 1'b0, 8'h5F), 4'h3, 1'b1, 12'h100, -1, 8'h00, 5'h00);
        exec(andop(1'b0, 1'b0, 8'h60), 4'h3, 1'b1, 12'h100, -1, 8'h00, 5'h00);
        exec(andop(1'b0, 1'b0, 8'h5F), 4'h3, 1'b0, 12'h100, -1, 8'h00, 5'h00);
        exec(andop(1'b1, 1'b0, 8'hFF), 4'h3, 1'b0, 12'h100, -1, 8'h00, 5'h00);
        // load collisions and early loads
        exec(andop(1'b1, 1'b1, 8'h44), 4'h5, 1'b0, 12'h000, 3, 8'hA5, 5'b01010);
        exec(andop(1'b0, 1'b1, 8'h45), 4'h5, 1'b0, 12'h000, 3, 8'h3C, 5'b10101);
        exec(andop(1'b0, 1'b0, 8'h10), 4'h0, 1'b0, 12'h000, 1, 8'hFF, 5'b00000);
        exec(andop(1'b0, 1'b0, 8'h11), 4'h0, 1'b0, 12'h000, 2, 8'h81, 5'b00111);
        exec(16'h1800, 4'h0, 1'b0, 12'h000, -1, 8'h00, 5'h00);

        for (int n = 0; n < 400; n++) begin
            logic [15:0] wd;
            int          sel, lp;
            sel = int'($urandom % 5);
            wd  = (sel != 0) ? {6'b000101, 10'($urandom)} : 16'($urandom);
            sel = int'($urandom % 8);
            lp  = (sel < 4) ? -1 : sel - 4;
            exec(wd, 4'($urandom), 1'($urandom), 12'($urandom), lp, 8'($urandom), 5'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule